// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

A slave that loses track of a transfer partway through a byte can be left holding SDA low, and then no controller can issue a START. This block gets such a bus moving again. When triggered, it takes the SCL and SDA pad drivers away from the normal controller through an override path. It toggles SCL a fixed number of times with SDA released, so that the stuck slave can shift out the rest of its byte. It then plays a short script that ends in a STOP condition.

Every step of the script lasts one half-period. The half-period is a parameter counted in system clock cycles. Both line outputs are open-drain values: 1 means released, 0 means pulled low. After the last step the block reads the SDA level seen on the bus and hands the pins back. It gives a one-cycle completion pulse and a sticky flag that is set when SDA was still held low.

Top module: `bus_clear_seq`

## Requirements
- R1: After reset, `ovr_en_o` is 0, `scl_o` and `sda_o` are 1 (released), and `done_o` and `busy_err_o` are 0.
- R2: A high `start_i` seen at a clock edge while idle sets `ovr_en_o` to 1 in the next cycle. It stays 1 for exactly (2·N_PULSES+4)·HALF_CYC cycles.
- R3: The sequence opens with N_PULSES clock pulses, each lasting 2·HALF_CYC cycles. In a pulse, `scl_o` is 1 for the first HALF_CYC cycles and 0 for the next HALF_CYC cycles. `sda_o` stays 1 throughout.
- R4: Four steps of HALF_CYC cycles follow the pulses, in this order: (SCL 0, SDA 1), (SCL 0, SDA 0), (SCL 1, SDA 0), (SCL 1, SDA 1). The last transition is the STOP condition.
- R5: In the cycle after the last step ends, `ovr_en_o` returns to 0 and `scl_o`/`sda_o` return to 1. `done_o` is 1 for that one cycle only.
- R6: `busy_err_o` takes the inverse of `sda_in_i` as sampled at the clock edge that ends the final step. The SDA level at any other time has no effect on it.
- R7: `busy_err_o` holds its value while idle. It is cleared in the first cycle of the next accepted sequence.
- R8: A `start_i` pulse while `ovr_en_o` is 1 is ignored: the step timing and the end of the running sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run the recovery script |
| sda_in_i | input | 1 | Synchronised SDA level seen on the bus |
| ovr_en_o | output | 1 | 1 while the sequencer owns both pins |
| scl_o | output | 1 | SCL override value, 1 = released, 0 = driven low |
| sda_o | output | 1 | SDA override value, 1 = released, 0 = driven low |
| done_o | output | 1 | One-cycle pulse when the script ends |
| busy_err_o | output | 1 | Sticky flag: SDA was still low at the end |

## Verification
Every output is a register. The first step therefore shows one cycle after the edge that samples `start_i`. Step n of the script is visible from cycle n·HALF_CYC to cycle (n+1)·HALF_CYC−1 after that edge. `done_o` and the error verdict appear at cycle (2·N_PULSES+4)·HALF_CYC. The SDA sample behind the verdict is the value driven just before that edge. The bench drives inputs and samples outputs on falling edges, counting cycles from the accepting edge. It compares every cycle of each run against this step table. It places SDA changes and stray triggers exactly one cycle before the edges that matter.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CLOCK,
        PH_STOP
    } phase_e;

    typedef enum logic [1:0] {
        ST_SETTLE,
        ST_SDA_LOW,
        ST_SCL_UP,
        ST_SDA_UP
    } stop_e;

    typedef struct packed {
        logic own;
        logic scl;
        logic sda;
    } pins_t;

    localparam pins_t PINS_IDLE = '{own: 1'b0, scl: 1'b1, sda: 1'b1};

    // Pin values for each step of the closing script (1 = released)
    function automatic pins_t stop_pins(input stop_e s);
        pins_t p;
        p.own = 1'b1;
        case (s)
            ST_SETTLE:  begin p.scl = 1'b0; p.sda = 1'b1; end
            ST_SDA_LOW: begin p.scl = 1'b0; p.sda = 1'b0; end
            ST_SCL_UP:  begin p.scl = 1'b1; p.sda = 1'b0; end
            default:    begin p.scl = 1'b1; p.sda = 1'b1; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bcs_half_timer.sv
`timescale 1ns/1ps
module bcs_half_timer #(
    parameter int unsigned HALF_CYC = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/bcs_step_ctrl.sv
`timescale 1ns/1ps
module bcs_step_ctrl
    import bcs_pkg::*;
#(
    parameter int unsigned N_PULSES = 9
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  start_i,
    input  logic  tick_i,
    input  logic  sda_in_i,
    output logic  run_o,
    output pins_t pins_o,
    output logic  done_o,
    output logic  err_o
);
    localparam int unsigned HALVES = 2 * N_PULSES;
    localparam int unsigned HW = (HALVES > 2) ? $clog2(HALVES) : 1;
    localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);

    typedef struct packed {
        phase_e        phase;
        logic [HW-1:0] half;
        stop_e         stp;
        pins_t         pins;
        logic          done;
        logic          err;
    } st_t;

    localparam st_t ST_RST = '{
        phase: PH_IDLE,
        half:  '0,
        stp:   ST_SETTLE,
        pins:  PINS_IDLE,
        done:  1'b0,
        err:   1'b0
    };

    st_t           s_d, s_q;
    logic [HW-1:0] half_nxt;
    stop_e         stp_nxt;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        half_nxt = s_q.half + 1'b1;
        stp_nxt  = stop_e'(s_q.stp + 2'd1);
        case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_CLOCK;
                    s_d.half  = '0;
                    s_d.err   = 1'b0;
                    s_d.pins  = '{own: 1'b1, scl: 1'b1, sda: 1'b1};
                end
            end
            PH_CLOCK: begin
                if (tick_i) begin
                    if (s_q.half == LAST_HALF) begin
                        s_d.phase = PH_STOP;
                        s_d.stp   = ST_SETTLE;
                        s_d.pins  = stop_pins(ST_SETTLE);
                    end else begin
                        s_d.half     = half_nxt;
                        s_d.pins.scl = ~half_nxt[0];
                    end
                end
            end
            PH_STOP: begin
                if (tick_i) begin
                    if (s_q.stp == ST_SDA_UP) begin
                        s_d.phase = PH_IDLE;
                        s_d.pins  = PINS_IDLE;
                        s_d.done  = 1'b1;
                        s_d.err   = ~sda_in_i;
                    end else begin
                        s_d.stp  = stp_nxt;
                        s_d.pins = stop_pins(stp_nxt);
                    end
                end
            end
            default: s_d = ST_RST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= ST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o  = (s_q.phase != PH_IDLE);
    assign pins_o = s_q.pins;
    assign done_o = s_q.done;
    assign err_o  = s_q.err;

endmodule

// File: rtl/bus_clear_seq.sv
`timescale 1ns/1ps
module bus_clear_seq
    import bcs_pkg::*;
#(
    parameter int unsigned HALF_CYC = 1000,
    parameter int unsigned N_PULSES = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic sda_in_i,
    output logic ovr_en_o,
    output logic scl_o,
    output logic sda_o,
    output logic done_o,
    output logic busy_err_o
);
    logic  run;
    logic  tick;
    pins_t pins;

    bcs_half_timer #(
        .HALF_CYC(HALF_CYC)
    ) u_timer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (run),
        .tick_o(tick)
    );

    bcs_step_ctrl #(
        .N_PULSES(N_PULSES)
    ) u_steps (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .tick_i  (tick),
        .sda_in_i(sda_in_i),
        .run_o   (run),
        .pins_o  (pins),
        .done_o  (done_o),
        .err_o   (busy_err_o)
    );

    assign ovr_en_o = pins.own;
    assign scl_o    = pins.scl;
    assign sda_o    = pins.sda;

endmodule

// File: rtl/bcs_chk.sv
`timescale 1ns/1ps
module bcs_chk #(
    parameter int unsigned N_PULSES = 9
) (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic ovr_en_o,
    input logic scl_o,
    input logic sda_o,
    input logic done_o,
    input logic busy_err_o
);
    logic        en_p, scl_p;
    int unsigned fall_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_p     <= 1'b0;
            scl_p    <= 1'b1;
            fall_cnt <= 0;
        end else begin
            en_p  <= ovr_en_o;
            scl_p <= scl_o;
            if (ovr_en_o && !en_p) begin
                fall_cnt <= 0;
            end else if (ovr_en_o && scl_p && !scl_o) begin
                fall_cnt <= fall_cnt + 1;
            end
        end
    end

    // R1
    idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ovr_en_o |-> (scl_o && sda_o));

    // R3
    pulse_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (fall_cnt == N_PULSES));

    // R4
    sda_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sda_o) |-> (!scl_o && ovr_en_o));

    // R4
    stop_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovr_en_o && $rose(sda_o)) |-> scl_o);

    // R5
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R5
    done_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ovr_en_o) |-> done_o);

    // R5
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !ovr_en_o);

    // R6
    err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_err_o) |-> done_o);

    // R7
    err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_err_o) |-> (ovr_en_o && $past(start_i)));

endmodule

bind bus_clear_seq bcs_chk #(
    .N_PULSES(N_PULSES)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ovr_en_o  (ovr_en_o),
    .scl_o     (scl_o),
    .sda_o     (sda_o),
    .done_o    (done_o),
    .busy_err_o(busy_err_o)
);

// File: tb/bus_clear_seq_tb.sv
`timescale 1ns/1ps
module bus_clear_seq_tb;
    localparam int unsigned HALF  = 4;
    localparam int unsigned NP    = 9;
    localparam int          TOT   = (2 * NP + 4) * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sda_in = 1'b1;
    logic ovr_en, scl, sda, done, err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_clear_seq #(
        .HALF_CYC(HALF),
        .N_PULSES(NP)
    ) u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .sda_in_i  (sda_in),
        .ovr_en_o  (ovr_en),
        .scl_o     (scl),
        .sda_o     (sda),
        .done_o    (done),
        .busy_err_o(err)
    );

    task automatic check(input bit ok, input string req, input string tag,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
        end
    endtask

    // Expected {own, scl, sda} k cycles after the accepting edge
    function automatic logic [2:0] exp_pins(input int k);
        int s;
        int j;
        s = k / HALF;
        if (s < 2 * NP) begin
            return {1'b1, (s % 2 == 0), 1'b1};
        end
        j = s - 2 * NP;
        return {1'b1, (j >= 2), (j == 0 || j == 3)};
    endfunction

    // mode: 0 free, 1 stuck, 2 frees after 5 SCL falls,
    //       3 high except low right before the last edge, 4 the reverse
    task automatic run_seq(input string tag, input int mode, input int restart_at,
                           input bit exp_err);
        int   falls = 0;
        logic prev_scl = 1'b1;
        @(negedge clk);
        start  = 1'b1;
        sda_in = (mode == 0 || mode == 3);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= TOT; k++) begin
            if (k < TOT) begin
                check({ovr_en, scl, sda} == exp_pins(k),
                      (k / HALF < 2 * NP) ? "R3" : "R4", tag,
                      int'({ovr_en, scl, sda}), int'(exp_pins(k)));
                check(done == 1'b0, "R5", tag, int'(done), 0);
            end else begin
                check({ovr_en, scl, sda} == 3'b011, "R5", tag,
                      int'({ovr_en, scl, sda}), 3);
                check(done == 1'b1, "R5", tag, int'(done), 1);
                check(err == exp_err, "R6", tag, int'(err), int'(exp_err));
            end
            if (k == 0) begin
                check(ovr_en == 1'b1, "R2", tag, int'(ovr_en), 1);
                check(err == 1'b0, "R7", tag, int'(err), 0);
            end
            if (prev_scl && !scl) falls++;
            prev_scl = scl;
            start = (k == restart_at);
            case (mode)
                0:       sda_in = 1'b1;
                1:       sda_in = 1'b0;
                2:       sda_in = (falls >= 5);
                3:       sda_in = (k != TOT - 1);
                default: sda_in = (k == TOT - 1);
            endcase
            @(negedge clk);
        end
        start = 1'b0;
        check(done == 1'b0, "R5", tag, int'(done), 0);
        check(err == exp_err, "R7", tag, int'(err), int'(exp_err));
    endtask

    task automatic t_reset();
        check(ovr_en == 1'b0, "R1", "reset", int'(ovr_en), 0);
        check(scl == 1'b1 && sda == 1'b1, "R1", "reset", int'({scl, sda}), 3);
        check(done == 1'b0, "R1", "reset", int'(done), 0);
        check(err == 1'b0, "R1", "reset", int'(err), 0);
    endtask

    task automatic t_clean_bus();
        run_seq("R3 free bus", 0, -1, 1'b0);
    endtask

    task automatic t_slave_frees();
        run_seq("R6 slave frees", 2, -1, 1'b0);
    endtask

    task automatic t_slave_stuck();
        run_seq("R6 stuck", 1, -1, 1'b1);
        sda_in = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(err == 1'b1, "R7", "sticky", int'(err), 1);
            check(ovr_en == 1'b0, "R7", "sticky idle", int'(ovr_en), 0);
        end
    endtask

    task automatic t_restart_clears();
        run_seq("R7 clear on start", 0, -1, 1'b0);
    endtask

    task automatic t_start_ignored();
        run_seq("R8 early", 0, 3, 1'b0);
        run_seq("R8 stop phase", 0, 2 * NP * HALF + 1, 1'b0);
        run_seq("R8 last cycle", 0, TOT - 1, 1'b0);
    endtask

    task automatic t_sample_edge();
        run_seq("R6 low at edge", 3, -1, 1'b1);
        run_seq("R6 high at edge", 4, -1, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_clean_bus();
        t_slave_frees();
        t_slave_stuck();
        t_restart_clears();
        t_start_ignored();
        t_sample_edge();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog [R2] actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule